// File: doc/BRIEF.md
# Zero-Biased Redundant Vote Combiner

This block merges redundant copies of a single logic signal into one decision. The copies come from several producer groups, each replicated a different number of times, and each copy carries its own valid strobe, so copies may land in different cycles. The producing logic precharges high and only discharges to reach 0. A spurious 0 is therefore the unlikely error, and the combiner is biased toward 0. It commits a 0 as soon as a configured number of zero votes has been collected, without waiting for the slower copies. It commits a 1 only when every copy has arrived and the zero count is still below that number.

Each evaluation window opens with a clear pulse. The window yields exactly one decision, marked by a one-cycle valid pulse. Votes that arrive after the decision are dropped until the next clear. A copy that votes twice in one window is counted once and raises a sticky error flag. Two counters report how many decisions were taken early on zeros and how many waited for the full set of votes. The group layout (one 4-bit replication count per group, group 0 in the lowest nibble, group 0's copies at the lowest vote indices), the zero threshold and the counter width are parameters.

Top module: `zbv_voter`

## Requirements
- R1: While reset is asserted and right after it is released, `dec_vld` is 0, `dec_val` is 1, `dup_err` is 0 and both counters are 0.
- R2: When a vote sampled at a clock edge brings the number of distinct zero votes in the window to `ZERO_THR`, `dec_vld` is 1 with `dec_val` 0 in the cycle after that edge, even if some votes are still missing.
- R3: When the last outstanding vote is sampled and the zero count is still below `ZERO_THR`, `dec_vld` is 1 with `dec_val` 1 in the cycle after that edge.
- R4: All votes strobed in the same cycle are counted together at that edge.
- R5: A window yields at most one decision. Votes sampled after it change neither `dec_vld`, `dec_val`, `dup_err` nor the counters.
- R6: A vote strobed again in the same undecided window is not counted a second time. It sets `dup_err`, which then stays 1 until reset.
- R7: `win_clr` empties the window. Votes strobed in the same cycle as `win_clr` are discarded.
- R8: `dec_val` holds its last decided value in every cycle where `dec_vld` is 0.
- R9: A 0 decision taken while some votes are missing increments `fast_cnt`. Every other decision increments `full_cnt`. Both counters wrap modulo 2^`CNT_W`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| win_clr | input | 1 | Opens a new evaluation window |
| vote_vld | input | NUM_VOTES | Per-copy vote strobe |
| vote_val | input | NUM_VOTES | Per-copy vote value |
| dec_vld | output | 1 | One-cycle decision pulse |
| dec_val | output | 1 | Decided value, held until the next decision |
| dup_err | output | 1 | Sticky flag: a copy voted twice in one window |
| fast_cnt | output | CNT_W | Count of early zero decisions |
| full_cnt | output | CNT_W | Count of decisions taken with all votes present |

## Verification
A lane that forgets a vote it has already recorded shows up within one window at the ports. A missed vote means a 1 decision never fires, and a recorded vote that was lost lets a repeated strobe be counted twice, so a 0 decision fires early. A decided flag that fails to latch shows the very next cycle, as a second `dec_vld` pulse or an unexpected `dup_err` when late votes arrive. Errors in the counter routing appear in the next decision's counter values. The bench runs every vote-value pattern through serial, reversed and simultaneous arrival orders and checks all outputs after every step.

// File: rtl/zbv_pkg.sv
package zbv_pkg;

  localparam int WAY_W    = 4;
  localparam int MAX_MODS = 16;

  // Sum of the per-group replication counts packed as WAY_W-bit fields.
  function automatic int total_votes(input int nmods, input logic [63:0] ways);
    int acc;
    acc = 0;
    for (int i = 0; i < MAX_MODS; i++) begin
      if (i < nmods) acc += int'(ways[i*WAY_W +: WAY_W]);
    end
    return acc;
  endfunction

endpackage

// File: rtl/zbv_lane.sv
module zbv_lane (
  input  logic clk,
  input  logic rst_n,
  input  logic clr,
  input  logic take,
  input  logic vld,
  input  logic val,
  output logic seen_q,
  output logic zero_q,
  output logic seen_d,
  output logic zero_d,
  output logic dup
);

  logic upd;

  always_comb begin
    seen_d = seen_q;
    zero_d = zero_q;
    upd    = 1'b0;
    if (clr) begin
      seen_d = 1'b0;
      zero_d = 1'b0;
      upd    = 1'b1;
    end else if (take && vld && !seen_q) begin
      seen_d = 1'b1;
      zero_d = ~val;
      upd    = 1'b1;
    end
  end

  assign dup = !clr && take && vld && seen_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      seen_q <= 1'b0;
      zero_q <= 1'b0;
    end else if (upd) begin
      seen_q <= seen_d;
      zero_q <= zero_d;
    end
  end

  // R6
  zero_implies_seen_chk: assert property (@(posedge clk) disable iff (!rst_n)
    zero_q |-> seen_q);

  // R7
  seen_drop_only_on_clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(seen_q) |-> $past(clr));

endmodule

// File: rtl/zbv_tally.sv
module zbv_tally #(
  parameter int NUM_VOTES = 4,
  parameter int ZERO_THR  = 2
) (
  input  logic [NUM_VOTES-1:0] seen_d,
  input  logic [NUM_VOTES-1:0] zero_d,
  input  logic                 decided_q,
  input  logic                 clr,
  output logic                 fire,
  output logic                 fire_val,
  output logic                 early
);

  localparam int CW = $clog2(NUM_VOTES + 1);

  logic [CW-1:0] zc;
  logic [CW-1:0] sc;
  logic          thr_hit;
  logic          all_in;

  always_comb begin
    zc = '0;
    sc = '0;
    for (int i = 0; i < NUM_VOTES; i++) begin
      zc = zc + CW'(zero_d[i]);
      sc = sc + CW'(seen_d[i]);
    end
  end

  assign thr_hit  = (zc >= CW'(ZERO_THR));
  assign all_in   = (sc == CW'(NUM_VOTES));
  assign fire     = !decided_q && !clr && (thr_hit || all_in);
  assign fire_val = !thr_hit;
  assign early    = thr_hit && !all_in;

endmodule

// File: rtl/zbv_stats.sv
module zbv_stats #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             fire,
  input  logic             early,
  output logic [CNT_W-1:0] fast_cnt,
  output logic [CNT_W-1:0] full_cnt
);

  logic             fast_en;
  logic             full_en;
  logic [CNT_W-1:0] fast_d;
  logic [CNT_W-1:0] full_d;

  always_comb begin
    fast_en = fire && early;
    full_en = fire && !early;
    fast_d  = fast_cnt + CNT_W'(1);
    full_d  = full_cnt + CNT_W'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) fast_cnt <= '0;
    else if (fast_en) fast_cnt <= fast_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) full_cnt <= '0;
    else if (full_en) full_cnt <= full_d;
  end

  // R9
  cnt_idle_without_fire_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !fire |=> ($stable(fast_cnt) && $stable(full_cnt)));

  // R9
  one_cnt_per_fire_chk: assert property (@(posedge clk) disable iff (!rst_n)
    fire |=> ($stable(fast_cnt) != $stable(full_cnt)));

endmodule

// File: rtl/zbv_voter.sv
module zbv_voter #(
  parameter int          NUM_MODS = 3,
  parameter logic [63:0] MOD_WAYS = 64'h123,
  parameter int          ZERO_THR = 1,
  parameter int          CNT_W    = 16,
  localparam int         NUM_VOTES = zbv_pkg::total_votes(NUM_MODS, MOD_WAYS)
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 win_clr,
  input  logic [NUM_VOTES-1:0] vote_vld,
  input  logic [NUM_VOTES-1:0] vote_val,
  output logic                 dec_vld,
  output logic                 dec_val,
  output logic                 dup_err,
  output logic [CNT_W-1:0]     fast_cnt,
  output logic [CNT_W-1:0]     full_cnt
);

  logic [NUM_VOTES-1:0] seen_q;
  logic [NUM_VOTES-1:0] zero_q;
  logic [NUM_VOTES-1:0] seen_d;
  logic [NUM_VOTES-1:0] zero_d;
  logic [NUM_VOTES-1:0] dup_v;

  logic decided_q, decided_d;
  logic dec_vld_d, dec_val_d;
  logic dup_d;
  logic fire, fire_val, early;

  for (genvar g = 0; g < NUM_VOTES; g++) begin : g_lane
    zbv_lane u_lane (
      .clk    (clk),
      .rst_n  (rst_n),
      .clr    (win_clr),
      .take   (!decided_q),
      .vld    (vote_vld[g]),
      .val    (vote_val[g]),
      .seen_q (seen_q[g]),
      .zero_q (zero_q[g]),
      .seen_d (seen_d[g]),
      .zero_d (zero_d[g]),
      .dup    (dup_v[g])
    );
  end

  zbv_tally #(
    .NUM_VOTES (NUM_VOTES),
    .ZERO_THR  (ZERO_THR)
  ) u_tally (
    .seen_d    (seen_d),
    .zero_d    (zero_d),
    .decided_q (decided_q),
    .clr       (win_clr),
    .fire      (fire),
    .fire_val  (fire_val),
    .early     (early)
  );

  zbv_stats #(
    .CNT_W (CNT_W)
  ) u_stats (
    .clk      (clk),
    .rst_n    (rst_n),
    .fire     (fire),
    .early    (early),
    .fast_cnt (fast_cnt),
    .full_cnt (full_cnt)
  );

  always_comb begin
    decided_d = win_clr ? 1'b0 : (decided_q || fire);
    dec_vld_d = fire;
    dec_val_d = fire ? fire_val : dec_val;
    dup_d     = dup_err || (|dup_v);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      decided_q <= 1'b0;
      dec_vld   <= 1'b0;
      dec_val   <= 1'b1;
      dup_err   <= 1'b0;
    end else begin
      decided_q <= decided_d;
      dec_vld   <= dec_vld_d;
      dec_val   <= dec_val_d;
      dup_err   <= dup_d;
    end
  end

  // R5
  single_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    dec_vld |=> !dec_vld);

  // R6
  dup_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    dup_err |=> dup_err);

  // R8
  dec_val_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !dec_vld |-> $stable(dec_val));

  // R3
  one_needs_all_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (dec_vld && dec_val) |-> (&seen_q));

  // R2
  zero_needs_thr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (dec_vld && !dec_val) |-> ($countones(zero_q) >= ZERO_THR));

endmodule

// File: tb/zbv_voter_bench.sv
module zbv_voter_bench;

  localparam int CLK_P = 10;
  localparam int NV    = 4;
  localparam int THR   = 2;
  localparam int CW    = 4;
  localparam logic [NV-1:0] ALL = '1;

  logic          clk;
  logic          rst_n;
  logic          win_clr;
  logic [NV-1:0] vote_vld;
  logic [NV-1:0] vote_val;
  logic          dec_vld;
  logic          dec_val;
  logic          dup_err;
  logic [CW-1:0] fast_cnt;
  logic [CW-1:0] full_cnt;

  int n_chk;
  int n_fail;
  bit done;

  logic [NV-1:0] ms;
  int            mz;
  bit            md;
  bit            mv;
  bit            mdup;
  bit            ef;
  int            efast;
  int            efull;

  zbv_voter #(
    .NUM_MODS (2),
    .MOD_WAYS (64'h13),
    .ZERO_THR (THR),
    .CNT_W    (CW)
  ) u_zbv_voter (
    .clk      (clk),
    .rst_n    (rst_n),
    .win_clr  (win_clr),
    .vote_vld (vote_vld),
    .vote_val (vote_val),
    .dec_vld  (dec_vld),
    .dec_val  (dec_val),
    .dup_err  (dup_err),
    .fast_cnt (fast_cnt),
    .full_cnt (full_cnt)
  );

  initial clk = 1'b0;
  always #(CLK_P/2) clk = ~clk;

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic check_outs();
    chk("R2/R3 dec_vld", 32'(dec_vld), 32'(ef));
    chk("R8 dec_val", 32'(dec_val), 32'(mv));
    chk("R6 dup_err", 32'(dup_err), 32'(mdup));
    chk("R9 fast_cnt", 32'(fast_cnt), 32'(efast % 16));
    chk("R9 full_cnt", 32'(full_cnt), 32'(efull % 16));
  endtask

  task automatic open_window();
    win_clr = 1'b1;
    @(negedge clk);
    win_clr = 1'b0;
    ms = '0; mz = 0; md = 1'b0; ef = 1'b0;
    check_outs();
  endtask

  task automatic step(input logic [NV-1:0] m, input logic [NV-1:0] v);
    logic [NV-1:0] nw;
    ef = 1'b0;
    if (!md) begin
      if ((m & ms) != '0) mdup = 1'b1;
      nw = m & ~ms;
      ms = ms | nw;
      mz += $countones(nw & ~v);
      if (mz >= THR) begin
        ef = 1'b1; mv = 1'b0;
        if (ms != ALL) efast++; else efull++;
      end else if (ms == ALL) begin
        ef = 1'b1; mv = 1'b1; efull++;
      end
      if (ef) md = 1'b1;
    end
    vote_vld = m;
    vote_val = v;
    @(negedge clk);
    vote_vld = '0;
    check_outs();
  endtask

  initial begin
    #(CLK_P * 200000);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    n_chk = 0; n_fail = 0; done = 1'b0;
    ms = '0; mz = 0; md = 1'b0; mv = 1'b1; mdup = 1'b0; ef = 1'b0;
    efast = 0; efull = 0;
    rst_n = 1'b0; win_clr = 1'b0; vote_vld = '0; vote_val = '0;
    repeat (2) @(negedge clk);
    // R1 during reset
    chk("R1 dec_vld", 32'(dec_vld), 0);
    chk("R1 dec_val", 32'(dec_val), 1);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 after release
    chk("R1 dup_err", 32'(dup_err), 0);
    chk("R1 fast_cnt", 32'(fast_cnt), 0);
    chk("R1 full_cnt", 32'(full_cnt), 0);

    // R2 R3 R4 R5: every value pattern, three arrival orders, then a late repeat
    for (int p = 0; p < 16; p++) begin
      for (int k = 0; k < 3; k++) begin
        open_window();
        if (k == 0) begin
          for (int i = 0; i < NV; i++) step(NV'(1 << i), NV'(p));
        end else if (k == 1) begin
          for (int i = NV - 1; i >= 0; i--) step(NV'(1 << i), NV'(p));
        end else begin
          step(ALL, NV'(p));
        end
        // R5: after the decision the same votes again change nothing
        step(ALL, ~NV'(p));
      end
    end

    // R7: votes presented together with the clear are discarded
    win_clr = 1'b1; vote_vld = ALL; vote_val = '0;
    @(negedge clk);
    win_clr = 1'b0; vote_vld = '0;
    ms = '0; mz = 0; md = 1'b0; ef = 1'b0;
    check_outs();
    step(4'b0001, 4'b0000);
    chk("R7 no decision from cleared votes", 32'(dec_vld), 0);
    step(4'b0010, 4'b0000);
    chk("R7 decision after two fresh zeros", 32'(dec_vld), 1);

    // R6: repeated zero vote counted once, flag sticky
    open_window();
    step(4'b0001, 4'b0000);
    step(4'b0001, 4'b0000);
    chk("R6 repeat not counted", 32'(dec_vld), 0);
    chk("R6 flag set", 32'(dup_err), 1);
    step(4'b0100, 4'b0000);
    chk("R6 second distinct zero decides", 32'(dec_val), 0);
    open_window();
    chk("R6 flag survives clear", 32'(dup_err), 1);

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

endmodule